// File: doc/BRIEF.md
# BCD Timekeeper with Storage Window

This block puts a calendar clock and a general-purpose byte store behind one synchronous byte-wide bus. A single address space is split in two: every offset except the topmost eight reaches plain read/write storage, and those eight bytes are clock registers holding a control byte, seconds, minutes, hours, weekday with a century flag, date, month and year. All time fields are kept and presented in packed BCD.

A one-cycle `sec_tick` pulse, produced elsewhere from a one-second reference, advances the time. Carries ripple through the calendar and account for month lengths and leap years. Software sets the time by writing registers. Each field is checked for range as it is written, and an illegal value is dropped without changing that field. A stop flag in the seconds register freezes the count. The space is 2 KB by default. A parameter widens it to 8 KB, and the clock registers then move to the top of the larger space.

Top module: `bcd_tod_nvram`

## Requirements
- R1: For an address below the clock registers, a written byte is returned on `bus_rdata` in the cycle after `bus_re` is sampled. All storage reads 0x00 after reset.
- R2: The clock registers take up the eight highest offsets of the space: 0x7F8–0x7FF with SPACE_AW=11, 0x1FF8–0x1FFF with SPACE_AW=13. In rising address order they are control, seconds, minutes, hours, weekday/century, date, month, year. They are read with the same one-cycle latency as storage.
- R3: A control write stores the byte with bit 5 cleared and bits 7 and 4 set. A read returns the stored byte.
- R4: Bit 7 of seconds is a stop flag and takes effect on every seconds write. While it is 1, ticks do not advance time. A seconds read returns {stop, seconds[6:0]}.
- R5: A seconds or minutes write uses data bits 6:0 and is applied only if they form valid BCD 00–59. An hours write uses bits 5:0 and is applied only if they form valid BCD 00–23.
- R6: A date write uses bits 4:0 and is applied only if the value is valid BCD and nonzero. A month write uses bits 4:0, valid 01–12. A year write uses all 8 bits, valid BCD 00–99. A nibble above 9 makes a value invalid.
- R7: A weekday/century write sets the weekday from bits 2:0 and the century flag from bit 6. A read returns the century flag in bit 6 and the weekday in bits 2:0, with all other bits 0.
- R8: A tick while not stopped adds one second. Each field wraps to its minimum and carries into the next: seconds, minutes, hours, date, month, year. At a day rollover the weekday also advances, wrapping from 7 to 1.
- R9: Month lengths are 31 days, or 30 for April, June, September and November. February has 28 days, or 29 when the year value mod 4 is 0. Year 99 rolls to 00 and toggles the century flag.
- R10: An address at or above the space size reads 0xFF, and a write to it changes nothing.
- R11: After reset the clock reads control 0x90, time 00:00:00, weekday 1, century 0, date 01, month 01, year 00, not stopped.
- R12: A tick that arrives in the same cycle as a clock-register write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | BUS_AW | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable; data follows one cycle later |
| bus_rdata | output | 8 | Read data, held until the next read |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |

## Verification
Time state is visible only through register reads. A wrong field therefore shows up at the first read that follows the tick or write that corrupted it, one cycle after `bus_re`. Carry faults appear only at rollovers, so the bench drives the clock to the last second of chosen days and reads every field after the next tick. This covers the ends of 30-day and 31-day months, February in leap and common years, and the end of a century. A write that should have been dropped, but was stored, shows at the next read of the same register. A decode fault that aliases outside addresses onto the space shows when storage or the year register is read back afterwards.

// File: rtl/bcd_tod_pkg.sv
package bcd_tod_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [2:0] wday;
    logic       cent;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
  } tod_t;

  localparam tod_t TOD_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                 wday: 3'd1, cent: 1'b0, date: 8'h01,
                                 month: 8'h01, year: 8'h00};

  // register index = low three address bits inside the clock window
  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_SEC   = 3'd1;
  localparam logic [2:0] SEL_MIN   = 3'd2;
  localparam logic [2:0] SEL_HOUR  = 3'd3;
  localparam logic [2:0] SEL_WDAY  = 3'd4;
  localparam logic [2:0] SEL_DATE  = 3'd5;
  localparam logic [2:0] SEL_MONTH = 3'd6;
  localparam logic [2:0] SEL_YEAR  = 3'd7;

  localparam logic [7:0] CTRL_CLEAR = 8'h20;
  localparam logic [7:0] CTRL_SET   = 8'h90;

  typedef enum logic [1:0] {SRC_RAM, SRC_CLK, SRC_NONE} src_e;

  function automatic logic bcd_ok(input logic [7:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*T + O has the same residue mod 4 as 2*T + O
  function automatic logic leap_year(input logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_nvram_store.sv
module bcd_nvram_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= mem[addr];
  end

endmodule

// File: rtl/bcd_tod_advance.sv
module bcd_tod_advance
  import bcd_tod_pkg::*;
(
  input  tod_t cur,
  output tod_t nxt
);
  logic       s_end, m_end, h_end, d_end, mo_end, y_end, day_roll;
  logic [7:0] dim;

  always_comb begin
    dim      = month_len(cur.month, cur.year);
    s_end    = cur.sec   >= 8'h59;
    m_end    = cur.min   >= 8'h59;
    h_end    = cur.hour  >= 8'h23;
    d_end    = cur.date  >= dim;
    mo_end   = cur.month >= 8'h12;
    y_end    = cur.year  >= 8'h99;
    day_roll = s_end && m_end && h_end;

    nxt     = cur;
    nxt.sec = s_end ? 8'h00 : bcd_step(cur.sec);
    if (s_end)
      nxt.min = m_end ? 8'h00 : bcd_step(cur.min);
    if (s_end && m_end)
      nxt.hour = h_end ? 8'h00 : bcd_step(cur.hour);
    if (day_roll) begin
      nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
      nxt.date = d_end ? 8'h01 : bcd_step(cur.date);
      if (d_end) begin
        nxt.month = mo_end ? 8'h01 : bcd_step(cur.month);
        if (mo_end) begin
          nxt.year = y_end ? 8'h00 : bcd_step(cur.year);
          if (y_end) nxt.cent = ~cur.cent;
        end
      end
    end
  end

endmodule

// File: rtl/bcd_tod_regs.sv
module bcd_tod_regs
  import bcd_tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] sel,
  input  logic [7:0] wr_data,
  input  logic       tick,
  output logic [7:0] rd_data
);
  tod_t       t_q;
  tod_t       t_nxt;
  logic       stop_q;
  logic [7:0] ctrl_q;
  logic [7:0] v7, v6, v5;

  bcd_tod_advance u_adv (
    .cur (t_q),
    .nxt (t_nxt)
  );

  assign v7 = {1'b0, wr_data[6:0]};
  assign v6 = {2'b0, wr_data[5:0]};
  assign v5 = {3'b0, wr_data[4:0]};

  // a register write owns the cycle; a coincident tick is discarded
  always_ff @(posedge clk) begin
    if (rst) begin
      t_q    <= TOD_RESET;
      stop_q <= 1'b0;
      ctrl_q <= CTRL_SET;
    end else if (wr_en) begin
      case (sel)
        SEL_CTRL: ctrl_q <= (wr_data & ~CTRL_CLEAR) | CTRL_SET;
        SEL_SEC: begin
          stop_q <= wr_data[7];
          if (bcd_ok(v7) && v7 <= 8'h59) t_q.sec <= v7;
        end
        SEL_MIN:   if (bcd_ok(v7) && v7 <= 8'h59) t_q.min <= v7;
        SEL_HOUR:  if (bcd_ok(v6) && v6 <= 8'h23) t_q.hour <= v6;
        SEL_WDAY: begin
          t_q.wday <= wr_data[2:0];
          t_q.cent <= wr_data[6];
        end
        SEL_DATE:  if (bcd_ok(v5) && v5 != 8'h00) t_q.date <= v5;
        SEL_MONTH: if (bcd_ok(v5) && v5 != 8'h00 && v5 <= 8'h12) t_q.month <= v5;
        SEL_YEAR:  if (bcd_ok(wr_data)) t_q.year <= wr_data;
        default: ;
      endcase
    end else if (tick && !stop_q) begin
      t_q <= t_nxt;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  rd_data = ctrl_q;
      SEL_SEC:   rd_data = {stop_q, t_q.sec[6:0]};
      SEL_MIN:   rd_data = t_q.min;
      SEL_HOUR:  rd_data = t_q.hour;
      SEL_WDAY:  rd_data = {1'b0, t_q.cent, 3'b000, t_q.wday};
      SEL_DATE:  rd_data = t_q.date;
      SEL_MONTH: rd_data = t_q.month;
      default:   rd_data = t_q.year;
    endcase
  end

  AST_CTRL_FORCED_BITS: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]);  // R3
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !wr_en) |=> $stable(t_q));  // R4
  AST_SEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    bcd_ok(t_q.sec) && t_q.sec <= 8'h59);  // R5
  AST_HOUR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    bcd_ok(t_q.hour) && t_q.hour <= 8'h23);  // R5
  AST_MONTH_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    t_q.month >= 8'h01 && t_q.month <= 8'h12 && bcd_ok(t_q.month));  // R6
  AST_TICK_MOVES_SEC: assert property (@(posedge clk) disable iff (rst)
    (tick && !stop_q && !wr_en) |=> (t_q.sec != $past(t_q.sec)));  // R8
  AST_WRITE_DROPS_TICK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel != SEL_SEC) |=> $stable(t_q.sec));  // R12

endmodule

// File: rtl/bcd_tod_nvram.sv
module bcd_tod_nvram
  import bcd_tod_pkg::*;
#(
  parameter int BUS_AW   = 16,
  parameter int SPACE_AW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  input  logic              sec_tick
);
  localparam int CLK_REGS = 8;
  localparam int SEL_W    = $clog2(CLK_REGS);

  logic       in_space, in_clk, in_ram;
  logic [7:0] ram_rd, tod_rd, clk_q;
  src_e       src_q;

  assign in_space = ~|bus_addr[BUS_AW-1:SPACE_AW];
  assign in_clk   = in_space && (&bus_addr[SPACE_AW-1:SEL_W]);
  assign in_ram   = in_space && !in_clk;

  bcd_nvram_store #(.AW(SPACE_AW), .DW(8)) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bus_we && in_ram),
    .rd_en (bus_re && in_ram),
    .addr  (bus_addr[SPACE_AW-1:0]),
    .wdata (bus_wdata),
    .rdata (ram_rd)
  );

  bcd_tod_regs u_tod (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_we && in_clk),
    .sel     (bus_addr[SEL_W-1:0]),
    .wr_data (bus_wdata),
    .tick    (sec_tick),
    .rd_data (tod_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_NONE;
      clk_q <= 8'hFF;
    end else if (bus_re) begin
      src_q <= in_ram ? SRC_RAM : (in_clk ? SRC_CLK : SRC_NONE);
      if (in_clk) clk_q <= tod_rd;
    end
  end

  always_comb begin
    case (src_q)
      SRC_RAM: bus_rdata = ram_rd;
      SRC_CLK: bus_rdata = clk_q;
      default: bus_rdata = 8'hFF;
    endcase
  end

  AST_OFF_SPACE_READS_FF: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !in_space) |=> (bus_rdata == 8'hFF));  // R10
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!bus_re && !$past(bus_re) && !bus_we && !$past(bus_we)) |=> $stable(bus_rdata));  // R1

endmodule

// File: tb/test_bcd_tod_nvram.sv
module test_bcd_tod_nvram;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_CTRL = 16'h07F8, A_SEC = 16'h07F9, A_MIN = 16'h07FA,
                          A_HOUR = 16'h07FB, A_WDAY = 16'h07FC, A_DATE = 16'h07FD,
                          A_MON = 16'h07FE, A_YEAR = 16'h07FF;

  logic        clk = 1'b0;
  logic        rst, bus_we, bus_re, sec_tick, pend;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, exp_v;
  string       tag_v;
  int          checks = 0, errors = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  bcd_tod_nvram #(.BUS_AW(16), .SPACE_AW(11)) i_bcd_tod_nvram (
    .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_we (bus_we), .bus_re (bus_re), .bus_rdata (bus_rdata), .sec_tick (sec_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= bus_re;
  end

  // monitor: compare one cycle after each sampled read
  always @(negedge clk) begin
    if (pend) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard underflow actual=%02h expected=none", bus_rdata);
      end else begin
        exp_v = exp_q.pop_front();
        tag_v = tag_q.pop_front();
        if (bus_rdata !== exp_v) begin
          errors++;
          $display("FAIL %s actual=%02h expected=%02h", tag_v, bus_rdata, exp_v);
        end
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic next_day();
    wr(A_SEC, 8'h59); wr(A_MIN, 8'h59); wr(A_HOUR, 8'h23);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired, all requirements: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_we = 1'b0; bus_re = 1'b0; sec_tick = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(16'h0000, 8'h00, "R1 storage reset");
    rd(A_CTRL, 8'h90, "R11 control reset");
    rd(A_SEC,  8'h00, "R11 seconds reset");
    rd(A_MIN,  8'h00, "R11 minutes reset");
    rd(A_HOUR, 8'h00, "R11 hours reset");
    rd(A_WDAY, 8'h01, "R11 weekday reset");
    rd(A_DATE, 8'h01, "R11 date reset");
    rd(A_MON,  8'h01, "R11 month reset");
    rd(A_YEAR, 8'h00, "R11 year reset");

    // storage
    wr(16'h0123, 8'hC3); wr(16'h07F7, 8'h5A);
    rd(16'h0123, 8'hC3, "R1 storage readback");
    rd(16'h07F7, 8'h5A, "R1 top storage byte, R2 window boundary");

    // outside the space
    wr(16'h0800, 8'hAA); wr(16'hFFFF, 8'h55);
    rd(16'h0800, 8'hFF, "R10 read above space");
    rd(16'hFFFF, 8'hFF, "R10 read at top of bus");
    rd(16'h0000, 8'h00, "R10 no alias into storage");
    rd(A_YEAR,   8'h00, "R10 no alias into year");

    // control
    wr(A_CTRL, 8'h2F); rd(A_CTRL, 8'h9F, "R3 forced bits");
    wr(A_CTRL, 8'h00); rd(A_CTRL, 8'h90, "R3 zero write");

    // weekday / century
    wr(A_WDAY, 8'hC5); rd(A_WDAY, 8'h45, "R7 century and weekday");
    wr(A_WDAY, 8'h03); rd(A_WDAY, 8'h03, "R7 century cleared");

    // range checks
    wr(A_SEC, 8'h45);  rd(A_SEC, 8'h45, "R5 seconds valid, R2 order");
    wr(A_SEC, 8'h60);  rd(A_SEC, 8'h45, "R5 seconds 60 dropped");
    wr(A_SEC, 8'h3A);  rd(A_SEC, 8'h45, "R5 seconds bad nibble dropped");
    wr(A_MIN, 8'h59);  rd(A_MIN, 8'h59, "R5 minutes 59");
    wr(A_MIN, 8'h5F);  rd(A_MIN, 8'h59, "R5 minutes bad nibble dropped");
    wr(A_HOUR, 8'hD5); rd(A_HOUR, 8'h15, "R5 hours masked to 6 bits");
    wr(A_HOUR, 8'h24); rd(A_HOUR, 8'h15, "R5 hours 24 dropped");
    wr(A_HOUR, 8'h1A); rd(A_HOUR, 8'h15, "R5 hours bad nibble dropped");
    wr(A_DATE, 8'h00); rd(A_DATE, 8'h01, "R6 date zero dropped");
    wr(A_DATE, 8'hF7); rd(A_DATE, 8'h17, "R6 date masked to 5 bits");
    wr(A_DATE, 8'h1A); rd(A_DATE, 8'h17, "R6 date bad nibble dropped");
    wr(A_MON, 8'h13);  rd(A_MON, 8'h01, "R6 month 13 dropped");
    wr(A_MON, 8'h00);  rd(A_MON, 8'h01, "R6 month zero dropped");
    wr(A_MON, 8'h11);  rd(A_MON, 8'h11, "R6 month valid");
    wr(A_YEAR, 8'h9A); rd(A_YEAR, 8'h00, "R6 year bad nibble dropped");
    wr(A_YEAR, 8'hA0); rd(A_YEAR, 8'h00, "R6 year above 99 dropped");
    wr(A_YEAR, 8'h42); rd(A_YEAR, 8'h42, "R6 year valid");

    // stop flag
    wr(A_SEC, 8'hB0);
    tick(); tick(); tick();
    rd(A_SEC, 8'hB0, "R4 stopped seconds frozen");
    wr(A_SEC, 8'h30);
    tick();
    rd(A_SEC, 8'h31, "R4 counting resumes");

    // tick coinciding with a register write
    bus_addr = A_MIN; bus_wdata = 8'h10; bus_we = 1'b1; sec_tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; sec_tick = 1'b0;
    rd(A_SEC, 8'h31, "R12 tick dropped on write");
    rd(A_MIN, 8'h10, "R12 write applied");

    // carries
    wr(A_SEC, 8'h09); tick();
    rd(A_SEC, 8'h10, "R8 BCD digit carry");
    wr(A_WDAY, 8'h07); wr(A_DATE, 8'h10); wr(A_MON, 8'h05); wr(A_YEAR, 8'h42);
    next_day();
    rd(A_SEC,  8'h00, "R8 seconds wrap");
    rd(A_MIN,  8'h00, "R8 minutes wrap");
    rd(A_HOUR, 8'h00, "R8 hours wrap");
    rd(A_WDAY, 8'h01, "R8 weekday 7 to 1");
    rd(A_DATE, 8'h11, "R8 date advance");
    rd(A_MON,  8'h05, "R8 month held");

    // leap February
    wr(A_YEAR, 8'h24); wr(A_MON, 8'h02); wr(A_DATE, 8'h19);
    for (int i = 0; i < 9; i++) next_day();
    rd(A_DATE, 8'h28, "R9 leap Feb 28");
    next_day();
    rd(A_DATE, 8'h29, "R9 leap Feb 29");
    rd(A_MON,  8'h02, "R9 leap still Feb");
    next_day();
    rd(A_DATE, 8'h01, "R9 leap to Mar 1");
    rd(A_MON,  8'h03, "R9 leap month Mar");

    // common February
    wr(A_YEAR, 8'h23); wr(A_MON, 8'h02); wr(A_DATE, 8'h19);
    for (int i = 0; i < 10; i++) next_day();
    rd(A_DATE, 8'h01, "R9 common Feb 28 to Mar 1");
    rd(A_MON,  8'h03, "R9 common month Mar");

    // 30-day month
    wr(A_MON, 8'h04); wr(A_DATE, 8'h19);
    for (int i = 0; i < 11; i++) next_day();
    rd(A_DATE, 8'h30, "R9 April 30");
    next_day();
    rd(A_DATE, 8'h01, "R9 April to May 1");
    rd(A_MON,  8'h05, "R9 month May");

    // end of century
    wr(A_YEAR, 8'h99); wr(A_MON, 8'h12); wr(A_DATE, 8'h19); wr(A_WDAY, 8'h05);
    for (int i = 0; i < 12; i++) next_day();
    rd(A_DATE, 8'h31, "R9 Dec 31");
    next_day();
    rd(A_DATE, 8'h01, "R9 Jan 1");
    rd(A_MON,  8'h01, "R9 month wrap");
    rd(A_YEAR, 8'h00, "R9 year 99 to 00");
    rd(A_WDAY, 8'h44, "R9 century toggled, R8 weekday 4");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard leftovers actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule